// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a data cache placed between a processor core and a main-memory port. It holds 256 sets of two lines each, and each line is 64 bytes. The core issues word reads and writes on 32-bit byte addresses. The cache compares the tags of both lines in the addressed set against the request. A hit returns or updates the word locally on the next cycle. A miss stalls the core while the cache runs a full-line transaction on the memory side.

Writes that hit never reach memory. They mark the line dirty instead. When a miss has to replace a dirty line, the cache first streams that line out to memory and then streams the new line in. Write misses allocate a line: the line is fetched first, and the write is then merged into it. Each set keeps one bit that names the way to replace next. Every hit and every refill points that bit at the other way.

Address split: tag = addr[31:14], set = addr[13:6], word = addr[5:2]. Bits [1:0] are not used. A memory line transfer is one address handshake followed by 16 word beats, in ascending word order.

Top module: `dcache_2way`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and no memory channel is active. Every line is invalid, so the first access to any address is a miss.
- R2: A read hit asserts rsp_valid for one cycle, in the cycle after the request is accepted. rsp_rdata is the word selected by addr[5:2]; addr[1:0] does not change the result. No memory transfer takes place.
- R3: A write hit responds in the cycle after acceptance and updates only the cached word. It causes no memory transfer, and later reads of that address return the written value.
- R4: Any hit sets the set's replacement bit to the way that did not hit. On a miss the victim is an invalid way if there is one (way 0 is checked first); otherwise it is the way named by the replacement bit.
- R5: On a miss, req_ready stays 0 until the response is given. The cache issues one read address equal to {tag, set, 6'b0}, accepts 16 read beats for words 0 to 15 in order, installs the whole line, and then responds.
- R6: If the victim is valid and dirty, the cache first issues a write address equal to {victim tag, set, 6'b0} and 16 write beats carrying the victim's words 0 to 15. All of this happens before the refill address is issued.
- R7: A clean or invalid victim is dropped with no write beats.
- R8: A write miss allocates the line: it refills the line, merges the written word, marks the line dirty and points the replacement bit at the other way. A later eviction of that line therefore writes the new word back.
- R9: An address stays stable until mem_aready is seen, and write data stays stable until mem_wready is seen. A beat moves only when both sides of its handshake are high. At most one of mem_avalid, mem_wvalid and mem_rready is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, meaningful for reads |
| mem_avalid | output | 1 | Memory line address valid |
| mem_aready | input | 1 | Memory accepts the address |
| mem_awrite | output | 1 | 1 for a write-back, 0 for a refill |
| mem_aaddr | output | 32 | Line-aligned memory address |
| mem_wvalid | output | 1 | Write-back beat valid |
| mem_wready | input | 1 | Memory accepts the write beat |
| mem_wdata | output | 32 | Write-back beat data |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rready | output | 1 | Cache accepts the refill beat |
| mem_rdata | input | 32 | Refill beat data |

## Verification
The hardest case to reach is a replacement where both ways are valid, the replacement bit points at a dirty line, and the other way holds a clean line that was reached through several hits. The bench builds this case from the core port alone. It first dirties a line with a write hit. It then brings in two more tags that map to the same set, and it issues hits that steer the replacement bit away from the dirty line and then back onto it. A fourth tag then forces the write-back, so the bench can check that the write-back comes before the refill and that the write-back carries the merged word. Memory handshakes are throttled on every third cycle throughout, so every hold-while-stalled rule is exercised in the same run.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WB_ADDR,
    S_WB_DATA,
    S_FILL_ADDR,
    S_FILL_DATA,
    S_DONE
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS  = 256,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  output logic [1:0]            rd_valid,
  output logic [1:0]            rd_dirty,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output logic                  rd_lru,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  dirty_en,
  input  logic                  dirty_way,
  input  logic                  lru_en,
  input  logic                  lru_val
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];

    // status bits: cleared by reset, written on refill or write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_en && (fill_way == 1'(w))) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (dirty_en && (dirty_way == 1'(w))) begin
        dirty_q[idx] <= 1'b1;
      end
    end

    // tag array: no reset, only meaningful once valid
    always_ff @(posedge clk) begin
      if (fill_en && (fill_way == 1'(w))) tag_q[idx] <= fill_tag;
    end

    assign rd_valid[w] = valid_q[idx];
    assign rd_dirty[w] = dirty_q[idx];
    assign rd_tag[w]   = tag_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[idx] <= lru_val;
  end

  assign rd_lru = lru_q[idx];
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int SETS   = 256,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  output logic [1:0][LINE_W-1:0] rd_line,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [WSEL_W-1:0]      wr_word,
  input  logic [WORD_W-1:0]      wr_data
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    // one word per cycle: refill beats and write hits share this port
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w)))
        line_q[idx][int'(wr_word)*WORD_W +: WORD_W] <= wr_data;
    end

    assign rd_line[w] = line_q[idx];
  end
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_avalid,
  input  logic              mem_aready,
  output logic              mem_awrite,
  output logic [ADDR_W-1:0] mem_aaddr,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  output logic              mem_rready,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int WORDS    = LINE_W / WORD_W;
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);

  dc_state_e state_q, state_d;
  logic [ADDR_W-1:0] lat_addr_q, lat_addr_d;
  logic              lat_we_q, lat_we_d;
  logic [WORD_W-1:0] lat_wdata_q, lat_wdata_d;
  logic              vway_q, vway_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [WORD_W-1:0] rsp_data_q, rsp_data_d;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [WSEL_W-1:0] cur_word;
  logic              unused_lo;

  logic [1:0]             t_valid, t_dirty, hit_w;
  logic [1:0][TAG_W-1:0]  t_tag;
  logic                   t_lru, hit_way, victim, way_sel;
  logic                   fill_en, dirty_en, dirty_way, lru_en, lru_val;
  logic [1:0][LINE_W-1:0] lines;
  logic [LINE_W-1:0]      sel_line;
  logic [WORD_W-1:0]      word_out, wb_word;
  logic                   d_we, d_way;
  logic [WSEL_W-1:0]      d_word;
  logic [WORD_W-1:0]      d_data;

  // the lookup follows the live request in IDLE and the held miss after it
  assign cur_addr  = (state_q == S_IDLE) ? req_addr : lat_addr_q;
  assign cur_idx   = cur_addr[OFF_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_word  = cur_addr[BYTE_OFF +: WSEL_W];
  assign unused_lo = ^cur_addr[BYTE_OFF-1:0];

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(cur_idx),
    .rd_valid(t_valid), .rd_dirty(t_dirty), .rd_tag(t_tag), .rd_lru(t_lru),
    .fill_en(fill_en), .fill_way(vway_q), .fill_tag(cur_tag),
    .dirty_en(dirty_en), .dirty_way(dirty_way),
    .lru_en(lru_en), .lru_val(lru_val)
  );

  dc_data_store #(.SETS(SETS), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
    .clk(clk), .idx(cur_idx), .rd_line(lines),
    .wr_en(d_we), .wr_way(d_way), .wr_word(d_word), .wr_data(d_data)
  );

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = t_valid[w] && (t_tag[w] == cur_tag);
  end

  assign hit_way  = hit_w[1];
  assign victim   = !t_valid[0] ? 1'b0 : (!t_valid[1] ? 1'b1 : t_lru);
  assign way_sel  = (state_q == S_IDLE) ? hit_way : vway_q;
  assign sel_line = lines[way_sel];
  assign word_out = sel_line[int'(cur_word)*WORD_W +: WORD_W];
  assign wb_word  = lines[vway_q][int'(beat_q)*WORD_W +: WORD_W];

  always_comb begin
    state_d     = state_q;
    lat_addr_d  = lat_addr_q;
    lat_we_d    = lat_we_q;
    lat_wdata_d = lat_wdata_q;
    vway_d      = vway_q;
    beat_d      = beat_q;
    rsp_valid_d = 1'b0;
    rsp_data_d  = rsp_data_q;
    fill_en     = 1'b0;
    dirty_en    = 1'b0;
    dirty_way   = way_sel;
    lru_en      = 1'b0;
    lru_val     = ~way_sel;
    d_we        = 1'b0;
    d_way       = way_sel;
    d_word      = cur_word;
    d_data      = (state_q == S_IDLE) ? req_wdata : lat_wdata_q;
    mem_avalid  = 1'b0;
    mem_awrite  = 1'b0;
    mem_aaddr   = {cur_tag, cur_idx, {OFF_W{1'b0}}};
    mem_wvalid  = 1'b0;
    mem_wdata   = wb_word;
    mem_rready  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (|hit_w) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = word_out;
            lru_en      = 1'b1;
            d_we        = req_write;
            dirty_en    = req_write;
          end else begin
            lat_addr_d  = req_addr;
            lat_we_d    = req_write;
            lat_wdata_d = req_wdata;
            vway_d      = victim;
            beat_d      = '0;
            state_d     = (t_valid[victim] && t_dirty[victim]) ? S_WB_ADDR : S_FILL_ADDR;
          end
        end
      end
      S_WB_ADDR: begin
        mem_avalid = 1'b1;
        mem_awrite = 1'b1;
        mem_aaddr  = {t_tag[vway_q], cur_idx, {OFF_W{1'b0}}};
        if (mem_aready) state_d = S_WB_DATA;
      end
      S_WB_DATA: begin
        mem_wvalid = 1'b1;
        if (mem_wready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == WSEL_W'(WORDS - 1)) state_d = S_FILL_ADDR;
        end
      end
      S_FILL_ADDR: begin
        mem_avalid = 1'b1;
        if (mem_aready) state_d = S_FILL_DATA;
      end
      S_FILL_DATA: begin
        mem_rready = 1'b1;
        d_word     = beat_q;
        d_data     = mem_rdata;
        if (mem_rvalid) begin
          d_we   = 1'b1;
          beat_d = beat_q + 1'b1;
          if (beat_q == WSEL_W'(WORDS - 1)) begin
            fill_en = 1'b1;
            state_d = S_DONE;
          end
        end
      end
      S_DONE: begin
        rsp_valid_d = 1'b1;
        rsp_data_d  = word_out;
        lru_en      = 1'b1;
        d_we        = lat_we_q;
        dirty_en    = lat_we_q;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      beat_q      <= beat_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    lat_addr_q  <= lat_addr_d;
    lat_we_q    <= lat_we_d;
    lat_wdata_q <= lat_wdata_d;
    vway_q      <= vway_d;
    rsp_data_q  <= rsp_data_d;
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/dcache_2way_chk.sv
module dcache_2way_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_avalid,
  input logic              mem_aready,
  input logic              mem_awrite,
  input logic [ADDR_W-1:0] mem_aaddr,
  input logic              mem_wvalid,
  input logic              mem_wready,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_rready
);
  // R5
  miss_blocks_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_avalid || mem_wvalid || mem_rready) |-> !req_ready);

  // R5
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_avalid |-> (mem_aaddr[OFF_W-1:0] == '0));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_avalid && !mem_aready) |=> (mem_avalid && $stable(mem_aaddr) && $stable(mem_awrite)));

  // R9
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata)));

  // R9
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_avalid, mem_wvalid, mem_rready}));

  // R2
  hit_or_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || !req_ready));
endmodule

bind dcache_2way dcache_2way_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_avalid(mem_avalid), .mem_aready(mem_aready),
  .mem_awrite(mem_awrite), .mem_aaddr(mem_aaddr), .mem_wvalid(mem_wvalid),
  .mem_wready(mem_wready), .mem_wdata(mem_wdata), .mem_rready(mem_rready)
);

// File: tb/tb_dcache_2way.sv
module tb_dcache_2way;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_avalid, mem_aready, mem_awrite;
  logic [31:0] mem_aaddr;
  logic        mem_wvalid, mem_wready;
  logic [31:0] mem_wdata;
  logic        mem_rvalid, mem_rready;
  logic [31:0] mem_rdata;

  dcache_2way dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_avalid(mem_avalid), .mem_aready(mem_aready), .mem_awrite(mem_awrite),
    .mem_aaddr(mem_aaddr), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rready(mem_rready),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [31:0] mem_m [int unsigned];
  logic [31:0] truth [int unsigned];

  int          alog_n = 0;
  logic [31:0] alog_addr [64];
  logic        alog_wr [64];
  int          rd_beats = 0;
  int          wr_beats = 0;
  logic        rd_active = 1'b0;
  logic [31:0] rd_base = '0, wr_base = '0;
  int          rd_beat = 0, wr_beat = 0;
  int          cyc = 0;

  function automatic logic [31:0] init_val(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [31:0] mem_get(logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return init_val(a);
  endfunction

  function automatic logic [31:0] truth_get(logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (truth.exists(w)) return truth[w];
    return init_val(w);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory-side monitor: records handshakes seen at the clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_avalid && mem_aready) begin
        if (alog_n < 64) begin
          alog_addr[alog_n] = mem_aaddr;
          alog_wr[alog_n]   = mem_awrite;
        end
        alog_n++;
        if (mem_awrite) begin
          wr_base = mem_aaddr; wr_beat = 0;
        end else begin
          rd_base = mem_aaddr; rd_beat = 0; rd_active = 1'b1;
        end
      end
      if (mem_rvalid && mem_rready) begin
        rd_beats++;
        if (rd_beat == 15) rd_active = 1'b0;
        rd_beat++;
      end
      if (mem_wvalid && mem_wready) begin
        mem_m[wr_base + 32'(wr_beat * 4)] = mem_wdata;
        wr_beat++;
        wr_beats++;
      end
    end
  end

  // memory-side driver: throttles every third cycle
  initial begin
    mem_aready = 1'b0; mem_wready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_aready = (cyc % 3) != 0;
      mem_wready = (cyc % 3) != 1;
      mem_rvalid = rd_active && ((cyc % 3) != 2);
      mem_rdata  = mem_get(rd_base + 32'(rd_beat * 4));
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat, output bit stalled);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    stalled = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 2000) begin
      if (!req_ready) stalled = 1'b1;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (wr) truth[{a[31:2], 2'b00}] = wd;
  endtask

  localparam logic [31:0] A = 32'h1001_ABC4;
  localparam logic [31:0] B = A ^ 32'h0000_4000;
  localparam logic [31:0] C = A ^ 32'h0000_8000;
  localparam logic [31:0] D = A ^ 32'h0000_C000;
  localparam logic [31:0] E = 32'h0000_1254;

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 0);
    chk(!mem_avalid && !mem_wvalid && !mem_rready, "R1", "memory idle",
        {29'b0, mem_avalid, mem_wvalid, mem_rready}, 0);
  endtask

  task automatic t_cold_miss();
    logic [31:0] rd; int lat; bit st;
    int n0 = alog_n, r0 = rd_beats, w0 = wr_beats;
    access(1'b0, A, '0, rd, lat, st);
    chk(lat > 1, "R1", "first access misses", 32'(lat), 2);
    chk(st, "R5", "core stalled during miss", 32'(st), 1);
    chk(rd == truth_get(A), "R5", "miss read data", rd, truth_get(A));
    chk(alog_n == n0 + 1, "R5", "one address handshake", 32'(alog_n - n0), 1);
    chk(alog_addr[n0] == {A[31:6], 6'b0} && !alog_wr[n0], "R5", "refill address",
        alog_addr[n0], {A[31:6], 6'b0});
    chk(rd_beats - r0 == 16, "R5", "refill beats", 32'(rd_beats - r0), 16);
    chk(wr_beats == w0, "R7", "no write-back of invalid victim", 32'(wr_beats - w0), 0);
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int lat; bit st;
    int n0 = alog_n;
    access(1'b0, {A[31:6], 6'h08}, '0, rd, lat, st);
    chk(lat == 1, "R2", "hit latency", 32'(lat), 1);
    chk(rd == truth_get({A[31:6], 6'h08}), "R2", "word 2", rd, truth_get({A[31:6], 6'h08}));
    access(1'b0, {A[31:6], 6'h3C}, '0, rd, lat, st);
    chk(rd == truth_get({A[31:6], 6'h3C}), "R2", "word 15", rd, truth_get({A[31:6], 6'h3C}));
    access(1'b0, A | 32'h3, '0, rd, lat, st);
    chk(rd == truth_get(A), "R2", "low address bits ignored", rd, truth_get(A));
    chk(alog_n == n0, "R2", "no memory traffic on hits", 32'(alog_n - n0), 0);
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int lat; bit st;
    int n0 = alog_n;
    access(1'b1, A, 32'hCAFE_0001, rd, lat, st);
    chk(lat == 1, "R3", "write hit latency", 32'(lat), 1);
    access(1'b0, A, '0, rd, lat, st);
    chk(rd == 32'hCAFE_0001, "R3", "read after write hit", rd, 32'hCAFE_0001);
    access(1'b0, A + 4, '0, rd, lat, st);
    chk(rd == truth_get(A + 4), "R3", "neighbour word untouched", rd, truth_get(A + 4));
    chk(alog_n == n0, "R3", "write hit stays local", 32'(alog_n - n0), 0);
  endtask

  task automatic t_replace();
    logic [31:0] rd; int lat; bit st;
    int w0, n0;
    w0 = wr_beats;
    access(1'b0, B, '0, rd, lat, st);
    chk(wr_beats == w0 && lat > 1, "R4", "B fills invalid way, dirty A kept",
        32'(wr_beats - w0), 0);
    access(1'b0, A, '0, rd, lat, st);
    chk(lat == 1, "R4", "A still resident", 32'(lat), 1);
    access(1'b0, C, '0, rd, lat, st);
    chk(wr_beats == w0, "R7", "clean B dropped silently", 32'(wr_beats - w0), 0);
    access(1'b0, A, '0, rd, lat, st);
    chk(lat == 1 && rd == 32'hCAFE_0001, "R4", "A survives C refill", rd, 32'hCAFE_0001);
    access(1'b0, B, '0, rd, lat, st);
    chk(lat > 1 && rd == truth_get(B), "R4", "B misses and evicts C", rd, truth_get(B));
    access(1'b0, B, '0, rd, lat, st);
    chk(lat == 1, "R4", "B hit steers replacement to A", 32'(lat), 1);
    n0 = alog_n;
    access(1'b0, D, '0, rd, lat, st);
    chk(wr_beats - w0 == 16, "R6", "dirty victim write beats", 32'(wr_beats - w0), 16);
    chk(alog_n == n0 + 2 && alog_wr[n0] && alog_addr[n0] == {A[31:6], 6'b0},
        "R6", "write-back address first", alog_addr[n0], {A[31:6], 6'b0});
    chk(!alog_wr[n0 + 1] && alog_addr[n0 + 1] == {D[31:6], 6'b0}, "R6",
        "refill after write-back", alog_addr[n0 + 1], {D[31:6], 6'b0});
    for (int i = 0; i < 16; i++) begin
      logic [31:0] wa = {A[31:6], 6'b0} + 32'(i * 4);
      chk(mem_get(wa) == truth_get(wa), "R9", "written-back word under stalls",
          mem_get(wa), truth_get(wa));
    end
    chk(rd == truth_get(D), "R5", "D read data", rd, truth_get(D));
  endtask

  task automatic t_write_alloc();
    logic [31:0] rd; int lat; bit st;
    int r0 = rd_beats, w0 = wr_beats;
    access(1'b1, E, 32'hBEEF_0042, rd, lat, st);
    chk(lat > 1 && rd_beats - r0 == 16 && wr_beats == w0, "R8",
        "write miss refills line", 32'(rd_beats - r0), 16);
    access(1'b0, E, '0, rd, lat, st);
    chk(lat == 1 && rd == 32'hBEEF_0042, "R8", "merged word", rd, 32'hBEEF_0042);
    access(1'b0, E + 4, '0, rd, lat, st);
    chk(rd == truth_get(E + 4), "R8", "rest of line from memory", rd, truth_get(E + 4));
    access(1'b0, E ^ 32'h4000, '0, rd, lat, st);
    chk(wr_beats == w0, "R8", "second tag takes invalid way", 32'(wr_beats - w0), 0);
    access(1'b0, E ^ 32'h8000, '0, rd, lat, st);
    chk(wr_beats - w0 == 16, "R8", "allocated line was dirty", 32'(wr_beats - w0), 16);
    chk(mem_get(E) == 32'hBEEF_0042, "R8", "merged word written back",
        mem_get(E), 32'hBEEF_0042);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_read_hit();
    t_write_hit();
    t_replace();
    t_write_alloc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule